// File: doc/BRIEF.md
# Seven-to-One Display Link Transmitter

This block turns a wide parallel pixel word into four narrow serial lanes plus a forwarded clock lane for a flat-panel link. Once per pixel clock it captures a 28-bit word, on the rising or the falling edge of that clock as chosen by an input. At the next frame boundary it hands the word to four 7-bit shift registers. The shift registers run on a bit clock seven times faster than the pixel clock. A fifth shift register sends a fixed 7-slot clock shape, so the receiver can find frame and bit alignment.

The bit clock and a load strobe come from a clock multiplier outside the block. The strobe is high during the last bit slot of each frame. A lock input stands in for the settle time of that multiplier. An active-low power-down input lowers the pad enable at once, and the pads are then read as high impedance. While the link is powered down or not locked, the shift registers are held at zero, so the first frame after recovery carries no stale bits.

Top module: `ser7_link_tx`

## Requirements
- R1: Every frame carries all 28 captured bits. Lane k carries word bits 7k to 7k+6.
- R2: Within a frame, lane k sends bit 7k+6 in slot 0 and bit 7k in slot 6, in descending order. Slot 0 is the first bit-clock cycle after the load edge.
- R3: The clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6 of every live frame. Its rising edge therefore falls two slots before the MSB slot.
- R4: With edge_sel_i high, the word sent is the one captured on the rising pix_clk_i edge. With edge_sel_i low, it is the one captured on the falling edge.
- R5: A word captured during frame n is loaded by the strobe edge that ends frame n and goes out in frame n+1.
- R6: With pwr_dn_ni low, oe_o is low and lane_o and clk_lane_o read zero, starting in the same cycle.
- R7: A load edge seen with pwr_dn_ni low clears the shift registers. After release, the frame that follows that edge is all zero on every lane.
- R8: With lock_i low, every lane stays at zero while oe_o follows pwr_dn_ni. Output starts again from the first load edge that sees lock_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk_i | input | 1 | Pixel clock used to capture words |
| bit_clk_i | input | 1 | Bit clock, seven times the pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Frame strobe, high during slot 6 |
| edge_sel_i | input | 1 | 1 selects the rising capture edge, 0 the falling edge |
| pwr_dn_ni | input | 1 | Power-down, active low |
| lock_i | input | 1 | Bit-clock settle flag |
| data_i | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Forwarded clock lane |
| oe_o | output | 1 | Pad enable; low means high impedance |

## Verification
The assertions assume that load_i pulses exactly once every seven bit clocks, and that pix_clk_i edges and data_i changes never coincide with a bit-clock edge. The bench builds both clocks from one bit-clock counter. It moves the pixel clock and the data only on bit-clock falling edges, in fixed slots. It presents a different word during each half of every pixel period, so the two capture edges see different values. The pwr_dn_ni, lock_i and edge_sel_i inputs change only between frames, except for one pwr_dn_ni release placed just after a load edge.

// File: rtl/ser7_pkg.sv
`timescale 1ns/1ps
package ser7_pkg;
  localparam int unsigned LANES_DEF = 4;
  localparam int unsigned SLOTS_DEF = 7;

  // slot s is sent from bit (slots-1-s); high for the first two and last two slots
  function automatic logic [31:0] fwd_clk_pattern(input int unsigned slots);
    logic [31:0] p;
    p = '0;
    for (int unsigned s = 0; s < slots; s++) begin
      if (s < 2 || s + 2 >= slots) p[slots-1-s] = 1'b1;
    end
    return p;
  endfunction
endpackage

// File: rtl/ser7_capture.sv
`timescale 1ns/1ps
module ser7_capture #(
  parameter int unsigned W = 28
) (
  input  logic         pix_clk_i,
  input  logic         rst_ni,
  input  logic         edge_sel_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] rise_q, fall_q;

  always_ff @(posedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= '0;
    else         rise_q <= data_i;
  end

  always_ff @(negedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= data_i;
  end

  assign word_o = edge_sel_i ? rise_q : fall_q;
endmodule

// File: rtl/ser7_shifter.sv
`timescale 1ns/1ps
module ser7_shifter #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [SLOTS-1:0] par_i,
  output logic             ser_o
);
  logic [SLOTS-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sreg_q <= '0;
    else if (clr_i)  sreg_q <= '0;
    else if (load_i) sreg_q <= par_i;
    else             sreg_q <= {sreg_q[SLOTS-2:0], 1'b0};
  end

  assign ser_o = sreg_q[SLOTS-1];

  AST_LOAD_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (ser_o == $past(par_i[SLOTS-1]))); // R2
  AST_CLEAR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ser_o == 1'b0)); // R8
endmodule

// File: rtl/ser7_link_tx.sv
`timescale 1ns/1ps
module ser7_link_tx
  import ser7_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned SLOTS = SLOTS_DEF
) (
  input  logic                   pix_clk_i,
  input  logic                   bit_clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   edge_sel_i,
  input  logic                   pwr_dn_ni,
  input  logic                   lock_i,
  input  logic [LANES*SLOTS-1:0] data_i,
  output logic [LANES-1:0]       lane_o,
  output logic                   clk_lane_o,
  output logic                   oe_o
);
  localparam int unsigned W  = LANES * SLOTS;
  localparam int unsigned SW = $clog2(SLOTS);
  localparam logic [31:0] PAT_FULL = fwd_clk_pattern(SLOTS);
  localparam logic [SLOTS-1:0] CLK_PAT = PAT_FULL[SLOTS-1:0];

  logic [W-1:0]     word;
  logic [LANES-1:0] lane_ser;
  logic             clk_ser;
  logic             clr;

  assign clr = !pwr_dn_ni || !lock_i;

  ser7_capture #(.W(W)) u_cap (
    .pix_clk_i (pix_clk_i),
    .rst_ni    (rst_ni),
    .edge_sel_i(edge_sel_i),
    .data_i    (data_i),
    .word_o    (word)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ser7_shifter #(.SLOTS(SLOTS)) u_sh (
      .clk_i (bit_clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .load_i(load_i),
      .par_i (word[k*SLOTS +: SLOTS]),
      .ser_o (lane_ser[k])
    );
  end

  ser7_shifter #(.SLOTS(SLOTS)) u_clk_sh (
    .clk_i (bit_clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .load_i(load_i),
    .par_i (CLK_PAT),
    .ser_o (clk_ser)
  );

  assign oe_o       = pwr_dn_ni;
  assign lane_o     = pwr_dn_ni ? lane_ser : '0;
  assign clk_lane_o = pwr_dn_ni & clk_ser;

  // slot tracking for the checks below
  logic [SW-1:0] slot_q;
  logic          seen_q, run_q;

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      seen_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (load_i) begin
        slot_q <= '0;
        seen_q <= 1'b1;
      end else if (slot_q == SW'(SLOTS-1)) begin
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
      if (clr)         run_q <= 1'b0;
      else if (load_i) run_q <= 1'b1;
    end
  end

  AST_LOAD_PERIOD: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (load_i && seen_q) |-> (slot_q == SW'(SLOTS-1))); // R5
  AST_CLK_SHAPE: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (run_q && pwr_dn_ni) |-> (clk_lane_o == CLK_PAT[SW'(SLOTS-1) - slot_q])); // R3
  AST_PD_QUIET: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |-> (!oe_o && lane_o == '0 && !clk_lane_o)); // R6
  AST_RELEASE_CLEAN: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    $rose(pwr_dn_ni) |-> (lane_o == '0 && !clk_lane_o)); // R7
endmodule

// File: tb/tb_ser7_link_tx.sv
`timescale 1ns/1ps
module tb_ser7_link_tx;
  localparam logic [6:0] PAT = 7'b1100011;

  typedef struct packed {
    logic        sel;
    logic [27:0] a;
    logic [27:0] b;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 28'h0000001, 28'hFFFFFFE},
    '{1'b1, 28'h8000000, 28'h7FFFFFF},
    '{1'b0, 28'hA5A5A5A, 28'h5A5A5A5},
    '{1'b0, 28'h1234567, 28'hFEDCBA9},
    '{1'b1, 28'hFFFFFFF, 28'h0000000},
    '{1'b0, 28'h0204081, 28'hC3C3C3C},
    '{1'b1, 28'h7F00000, 28'h00001FC},
    '{1'b1, 28'h0C0FE01, 28'h3E007F0}
  };

  logic        bit_clk = 1'b0, pix_clk = 1'b0, rst_n = 1'b0, load = 1'b0;
  logic        edge_sel = 1'b1, pwr_n = 1'b1, lock = 1'b1;
  logic [27:0] data = '0;
  logic [3:0]  lane;
  logic        clk_lane, oe;

  int errors = 0, checks = 0;
  logic [27:0] last_a = '0, rise_cap = '0, fall_cap = '0, exp_word = '0;
  logic [6:0]  exp_clk = '0;
  logic        primed = 1'b0;
  bit          done = 1'b0;

  always #2.5 bit_clk = ~bit_clk;

  ser7_link_tx dut (
    .pix_clk_i (pix_clk),
    .bit_clk_i (bit_clk),
    .rst_ni    (rst_n),
    .load_i    (load),
    .edge_sel_i(edge_sel),
    .pwr_dn_ni (pwr_n),
    .lock_i    (lock),
    .data_i    (data),
    .lane_o    (lane),
    .clk_lane_o(clk_lane),
    .oe_o      (oe)
  );

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected content of the next frame, from the state at its load edge
  task automatic prepare();
    if (primed && pwr_n && lock) begin
      exp_word = edge_sel ? rise_cap : fall_cap;
      exp_clk  = PAT;
    end else begin
      exp_word = '0;
      exp_clk  = '0;
    end
  endtask

  // one frame: deserialize all lanes and drive pixel clock, data and strobe
  task automatic frame(input string tag, input logic [27:0] a_next, input logic [27:0] b_this);
    logic [27:0] rec;
    logic [6:0]  rc;
    logic        oe_bad;
    rec = '0; rc = '0; oe_bad = 1'b0;
    rise_cap = last_a;
    for (int s = 0; s < 7; s++) begin
      @(negedge bit_clk);
      for (int k = 0; k < 4; k++) rec[7*k + 6 - s] = lane[k];
      rc[6-s] = clk_lane;
      if (oe !== pwr_n) oe_bad = 1'b1;
      load = (s == 6);
      if (s == 1) pix_clk = 1'b1;
      if (s == 2) data = b_this;
      if (s == 4) pix_clk = 1'b0;
      if (s == 5) data = a_next;
    end
    fall_cap = b_this;
    last_a   = a_next;
    primed   = 1'b1;
    check({tag, " R1 R2 R4 R5 word"}, rec === exp_word, {4'h0, rec}, {4'h0, exp_word});
    check({tag, " R3 clock lane"}, rc === exp_clk, {25'h0, rc}, {25'h0, exp_clk});
    check({tag, " R6 oe"}, !oe_bad, {31'h0, oe_bad}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge bit_clk);
    check("R7 reset lanes", lane === 4'h0 && clk_lane === 1'b0, {27'h0, clk_lane, lane}, 32'h0);
    check("R6 reset oe", oe === 1'b1, {31'h0, oe}, 32'h1);
    rst_n = 1'b1;

    prepare();
    for (int i = 0; i < 8; i++) begin
      edge_sel = VEC[i].sel;
      prepare();
      frame("table", VEC[i].a, VEC[i].b);
    end

    // R6: power-down takes effect at once
    pwr_n = 1'b0;
    #1;
    check("R6 pd immediate", oe === 1'b0 && lane === 4'h0 && clk_lane === 1'b0,
          {26'h0, oe, clk_lane, lane}, 32'h0);
    prepare();
    frame("R6 pd", 28'h9ABCDEF, 28'h1357924);
    prepare();
    frame("R6 pd", 28'h2468ACE, 28'hFFF0000);
    prepare();
    // R7: release right after a cleared load edge, frame must be empty
    @(posedge bit_clk);
    #1 pwr_n = 1'b1;
    frame("R7 release", 28'h0F0F0F0, 28'h1111111);
    edge_sel = 1'b0;
    prepare();
    frame("R7 resume", 28'h6666666, 28'h0ABCDE0);
    prepare();
    frame("R7 resume", 28'h5555555, 28'h3333333);

    // R8: unlocked link stays silent, then recovers
    lock = 1'b0;
    prepare();
    frame("R8 unlocked", 28'h7777777, 28'h4444444);
    prepare();
    frame("R8 unlocked", 28'h0000F00, 28'h00F0000);
    lock = 1'b1;
    edge_sel = 1'b1;
    prepare();
    frame("R8 relock", 28'h2222222, 28'h8888888);
    prepare();
    frame("R8 relock", 28'h0000000, 28'h0000000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule